// File: doc/BRIEF.md
# I2C Master Serial Clock Generator with Stretch Tolerance

This block produces the serial clock of an I2C master from the system clock. It pulls the clock line down through an open-drain style output: it only asserts a drive-low enable and never drives the line high. One SCL period is a low phase of 6 units and a high phase of 4 units. Each unit lasts 2 × (1 + P) system clocks, where P is the prescale value captured at the start of the period. The nominal period is therefore 20 × (1 + P) system clocks. For example, P = 7 gives 160 clocks, which is 375 kHz from a 60 MHz clock.

After letting go of the line, the generator does not start timing the high phase. It first waits until its own synchronized view of the line reads high. A slave that holds the clock low, or a slow RC rise on the pull-up, therefore lengthens the period by exactly the number of cycles the line stayed low. The high-phase count is shortened by the fixed input latency (two synchronizer stages plus one decision cycle), so a line that rises at once gives exactly the nominal period. The cycles lost to stretching in the most recent period are reported, saturated to the width of the output.

A byte engine sits beside this block. It uses two phase strobes: one marks the start of each low phase, and the other marks the moment the line has been seen high. Dropping the run input stops the clock. A low phase or a wait for the line is abandoned at once. A high phase that is already running is completed first, and the line is left released.

Top module: `scl_gen`

## Requirements
- R1: While reset is held and after its release with run low, the drive-low output, both strobes and the stretch count are all 0.
- R2: When run is high in idle, the next clock edge asserts drive-low, and the falling strobe is high for that one cycle. Drive-low never rises without the falling strobe.
- R3: Drive-low stays asserted for exactly 12 × (1 + P) cycles, where P is the prescale value sampled on the edge that started the period.
- R4: If the line goes high in the same cycle it is released, the time from one falling strobe to the next is exactly 20 × (1 + P) cycles.
- R5: If the line stays low for d cycles after release, the high strobe appears 12 × (1 + P) + d + 3 cycles after the falling strobe. The next falling strobe follows 8 × (1 + P) − 3 cycles after that, giving a period of 20 × (1 + P) + d. The high strobe appears only after the synchronized line has been seen high.
- R6: On each high strobe, the stretch count becomes d, saturated at 2^W − 1 for a count width W. It holds that value until the next high strobe.
- R7: Dropping run during a low phase, or while waiting for the line, releases the line on the next edge. No further strobes follow while run stays low.
- R8: Dropping run during a high phase does not shorten it. If run is high again at its end, the next period starts on the nominal cycle. If run is still low, the block goes idle with the line released.
- R9: A prescale change made during a period takes effect only when the next period starts.
- R10: Each strobe is a single-cycle pulse, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request for the serial clock |
| prescale | input | PRESCALE_W | Prescale value P; one unit is 2 × (1 + P) clocks |
| scl_in | input | 1 | Raw level of the serial clock line (asynchronous) |
| scl_drive_low | output | 1 | Open-drain pull-down enable for the clock line |
| fall_stb | output | 1 | One-cycle pulse at the start of each low phase |
| high_stb | output | 1 | One-cycle pulse when the line has been seen high and high timing begins |
| stretch_cycles | output | STRETCH_W | Cycles the line stayed low after release in the latest period |

## Verification
The bench models the clock line so that it rises a chosen number of cycles d after release. It sweeps every prescale value from 0 to 7 against several values of d, including zero, one, small values and a value that overflows the narrowed stretch counter. The zero-delay runs separate the nominal period from any latency error. The non-zero runs show whether the wait is counted from the observed rise rather than from the release, and whether the reported stretch matches d. Separate runs drop run during each phase, both with a brief dip and with a lasting drop in the high phase, and change prescale inside a period. These show which phases may be cut short and when a new prescale value is picked up.

// File: rtl/scl_gen_pkg.sv
// Package: shared types for the serial clock generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package scl_gen_pkg;

    // Phase of the generated clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // line released, not running
        PH_LOW  = 2'd1,  // pulling the line low, timing the low phase
        PH_WAIT = 2'd2,  // line released, waiting to see it high
        PH_HIGH = 2'd3   // line seen high, timing the high phase
    } phase_t;

endpackage

// File: rtl/scl_sync.sv
// Module: scl_sync
// Brings the asynchronous clock-line level into the system clock domain
// through a chain of STAGES flops. Assumes an idle bus reads high, so the
// chain resets to ones. STAGES must be at least 2.
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/scl_phase_timer.sv
// Module: scl_phase_timer
// Down-counter used to time one phase. Loading length L makes expire go
// high in the L-th cycle after the load edge, so a phase left when expire
// is seen lasts exactly L cycles. Assumes L >= 1.
module scl_phase_timer #(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    output logic             expire
);

    logic [LEN_W-1:0] cnt_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    assign expire = (cnt_q == LEN_W'(1));

endmodule

// File: rtl/scl_stretch_meter.sv
// Module: scl_stretch_meter
// Counts the cycles spent waiting for the clock line to read high. When the
// wait ends, it publishes the count minus the fixed synchronizer latency,
// saturated to the output width. Assumes in_wait is high for the whole wait
// and that seen_high ends it.
module scl_stretch_meter #(
    parameter int STRETCH_W   = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_wait,
    input  logic                 seen_high,
    output logic [STRETCH_W-1:0] stretch_cycles
);

    localparam int CNT_W = STRETCH_W + 2;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] OUT_MAX = CNT_W'((2 ** STRETCH_W) - 1);
    localparam logic [CNT_W-1:0] LAT     = CNT_W'(SYNC_STAGES);

    logic [CNT_W-1:0] wait_q;
    logic [CNT_W-1:0] extra;
    logic             capture;

    assign capture = in_wait && seen_high;

    // Remove the synchronizer latency and clip to the output range.
    always_comb begin
        if (wait_q <= LAT) begin
            extra = '0;
        end else if ((wait_q - LAT) > OUT_MAX) begin
            extra = OUT_MAX;
        end else begin
            extra = wait_q - LAT;
        end
    end

    // Count wait cycles with saturation; clear outside the wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (!in_wait || capture) begin
            wait_q <= '0;
        end else if (wait_q != CNT_MAX) begin
            wait_q <= wait_q + CNT_W'(1);
        end
    end

    // Publish the stretch length when the wait ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stretch_cycles <= '0;
        end else if (capture) begin
            stretch_cycles <= extra[STRETCH_W-1:0];
        end
    end

endmodule

// File: rtl/scl_gen.sv
// Module: scl_gen (top)
// Generates an I2C master serial clock with a low phase of LOW_UNITS units
// and a high phase of HIGH_UNITS units. Each unit is 2*(1+P) clocks, with P
// captured at the start of each period. High timing starts only once the
// synchronized line reads high. The high count is shortened by the input
// latency, so a line that rises at once gives the nominal period.
// Assumes 2*HIGH_UNITS > SYNC_STAGES + 1 and an open-drain line that cannot
// read high while this block pulls it low.
module scl_gen #(
    parameter int PRESCALE_W  = 8,
    parameter int LOW_UNITS   = 6,
    parameter int HIGH_UNITS  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int STRETCH_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [PRESCALE_W-1:0] prescale,
    input  logic                  scl_in,
    output logic                  scl_drive_low,
    output logic                  fall_stb,
    output logic                  high_stb,
    output logic [STRETCH_W-1:0]  stretch_cycles
);
    import scl_gen_pkg::*;

    localparam int MAX_UNITS = (LOW_UNITS > HIGH_UNITS) ? LOW_UNITS : HIGH_UNITS;
    localparam int LEN_W     = PRESCALE_W + $clog2(2 * MAX_UNITS) + 1;
    localparam int WAIT_LAT  = SYNC_STAGES + 1;

    phase_t                state_q;
    logic [PRESCALE_W-1:0] tpr_q;
    logic                  scl_seen;
    logic                  expire;
    logic                  start_low;
    logic                  start_high;
    logic                  tmr_load;
    logic [LEN_W-1:0]      low_len;
    logic [LEN_W-1:0]      high_load;
    logic [LEN_W-1:0]      tmr_val;

    scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (scl_in),
        .q_sync  (scl_seen)
    );

    // Phase lengths: the low phase uses the live prescale value (it is
    // captured on the same edge), the high phase uses the captured value.
    assign low_len   = LEN_W'(2 * LOW_UNITS) * (LEN_W'(prescale) + LEN_W'(1));
    assign high_load = LEN_W'(2 * HIGH_UNITS) * (LEN_W'(tpr_q) + LEN_W'(1))
                     - LEN_W'(WAIT_LAT);

    // Decide which phase starts on the coming edge.
    always_comb begin
        start_low  = enable && ((state_q == PH_IDLE) ||
                                ((state_q == PH_HIGH) && expire));
        start_high = enable && (state_q == PH_WAIT) && scl_seen;
        tmr_load   = start_low || start_high;
        tmr_val    = start_low ? low_len : high_load;
    end

    scl_phase_timer #(.LEN_W(LEN_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    // Phase sequencer: drives the line, the strobes and the prescale capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= PH_IDLE;
            scl_drive_low <= 1'b0;
            fall_stb      <= 1'b0;
            high_stb      <= 1'b0;
            tpr_q         <= '0;
        end else begin
            fall_stb <= 1'b0;
            high_stb <= 1'b0;
            case (state_q)
                PH_IDLE: begin
                    if (start_low) begin
                        state_q       <= PH_LOW;
                        scl_drive_low <= 1'b1;
                        fall_stb      <= 1'b1;
                        tpr_q         <= prescale;
                    end
                end
                PH_LOW: begin
                    if (!enable) begin
                        state_q       <= PH_IDLE;
                        scl_drive_low <= 1'b0;
                    end else if (expire) begin
                        state_q       <= PH_WAIT;
                        scl_drive_low <= 1'b0;
                    end
                end
                PH_WAIT: begin
                    if (!enable) begin
                        state_q <= PH_IDLE;
                    end else if (start_high) begin
                        state_q  <= PH_HIGH;
                        high_stb <= 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (start_low) begin
                        state_q       <= PH_LOW;
                        scl_drive_low <= 1'b1;
                        fall_stb      <= 1'b1;
                        tpr_q         <= prescale;
                    end else if (expire) begin
                        state_q <= PH_IDLE;
                    end
                end
                default: begin
                    state_q       <= PH_IDLE;
                    scl_drive_low <= 1'b0;
                end
            endcase
        end
    end

    scl_stretch_meter #(
        .STRETCH_W   (STRETCH_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_meter (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_wait        (state_q == PH_WAIT),
        .seen_high      (scl_seen),
        .stretch_cycles (stretch_cycles)
    );

endmodule

// File: rtl/scl_gen_chk.sv
// Module: scl_gen_chk
// Property checker attached to scl_gen. It relates the outputs to each other
// and to the synchronized line level over time. Assumes synchronous
// active-low reset.
module scl_gen_chk #(
    parameter int STRETCH_W = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic                 scl_seen,
    input logic                 scl_drive_low,
    input logic                 fall_stb,
    input logic                 high_stb,
    input logic [STRETCH_W-1:0] stretch_cycles
);

    // R2
    fall_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (scl_drive_low && !$past(scl_drive_low)));

    // R2
    low_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && !fall_stb) |-> $past(scl_drive_low));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb && high_stb));

    // R10
    high_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_stb |=> !high_stb);

    // R5
    high_after_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        high_stb |-> (!scl_drive_low && $past(scl_seen)));

    // R7
    no_fall_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fall_stb);

    // R6
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !high_stb |-> $stable(stretch_cycles));

endmodule

bind scl_gen scl_gen_chk #(.STRETCH_W(STRETCH_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .scl_seen       (scl_seen),
    .scl_drive_low  (scl_drive_low),
    .fall_stb       (fall_stb),
    .high_stb       (high_stb),
    .stretch_cycles (stretch_cycles)
);

// File: tb/scl_gen_tb.sv
// Bench for scl_gen: sweeps the prescale value against line rise delays and
// drives enable and prescale changes in each phase. Expected values come
// from the requirement formulas.
module scl_gen_tb;

    localparam int PW = 4;
    localparam int SW = 4;
    localparam int SMAX = (2 ** SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [PW-1:0] prescale = '0;
    logic          scl_line;
    logic          scl_drive_low;
    logic          fall_stb;
    logic          high_stb;
    logic [SW-1:0] stretch_cycles;

    int cyc = 0;
    int rel_cnt = 0;
    int hold_d = 0;
    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // Count clock edges and the cycles since the line was released.
    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rel_cnt <= scl_drive_low ? 0 : ((rel_cnt < 100000) ? rel_cnt + 1 : rel_cnt);
    end

    // Open-drain line model: low while pulled, high d cycles after release.
    assign scl_line = !scl_drive_low && (rel_cnt >= hold_d);

    scl_gen #(
        .PRESCALE_W (PW),
        .STRETCH_W  (SW)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .prescale       (prescale),
        .scl_in         (scl_line),
        .scl_drive_low  (scl_drive_low),
        .fall_stb       (fall_stb),
        .high_stb       (high_stb),
        .stretch_cycles (stretch_cycles)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic wait_fall(output int t);
        while (!fall_stb) @(negedge clk);
        t = cyc;
    endtask

    task automatic wait_high(output int t);
        while (!high_stb) @(negedge clk);
        t = cyc;
    endtask

    task automatic go_idle();
        @(negedge clk);
        enable = 1'b0;
        repeat (4 * 20 * 16) begin
            @(negedge clk);
            if (!scl_drive_low && rel_cnt > 200) break;
        end
        hold_d = 0;
        repeat (4) @(negedge clk);
    endtask

    // One full period for prescale p and rise delay d, starting from idle.
    task automatic sweep_point(input int p, input int d);
        int t0, th, t1, lowc, exp_s;
        prescale = PW'(p);
        hold_d   = d;
        enable   = 1'b1;
        @(negedge clk);
        // R2: the period starts on the next edge with the strobe.
        check(fall_stb && scl_drive_low, "R2", {fall_stb, scl_drive_low}, 3);
        t0 = cyc;
        lowc = 0;
        while (scl_drive_low) begin
            lowc++;
            @(negedge clk);
        end
        // R3: length of the low phase.
        check(lowc == 12 * (1 + p), "R3", lowc, 12 * (1 + p));
        wait_high(th);
        check(th - t0 == 12 * (1 + p) + d + 3, "R5", th - t0, 12 * (1 + p) + d + 3);
        exp_s = (d > SMAX) ? SMAX : d;
        // R6: published stretch length.
        check(int'(stretch_cycles) == exp_s, "R6", int'(stretch_cycles), exp_s);
        @(negedge clk);
        // R10: the high strobe lasts one cycle.
        check(!high_stb, "R10", high_stb, 0);
        wait_fall(t1);
        if (d == 0)
            check(t1 - t0 == 20 * (1 + p), "R4", t1 - t0, 20 * (1 + p));
        else
            check(t1 - t0 == 20 * (1 + p) + d, "R5", t1 - t0, 20 * (1 + p) + d);
        check(t1 - th == 8 * (1 + p) - 3, "R5", t1 - th, 8 * (1 + p) - 3);
        // R7: disabling in the low phase releases the line on the next edge.
        enable = 1'b0;
        @(negedge clk);
        check(!scl_drive_low, "R7", scl_drive_low, 0);
        go_idle();
    endtask

    initial begin
        int t0, th, t1, t2, bad;
        repeat (3) @(negedge clk);
        // R1: state during reset.
        check(!scl_drive_low && !fall_stb && !high_stb && stretch_cycles == '0,
              "R1", {scl_drive_low, fall_stb, high_stb}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: stays quiet after reset with run low.
        check(!scl_drive_low && !fall_stb && !high_stb && stretch_cycles == '0,
              "R1", {scl_drive_low, fall_stb, high_stb}, 0);

        // Main sweep: prescale 0..7 against several rise delays (R3-R6).
        for (int p = 0; p < 8; p++) begin
            foreach (sweep_d[i]) sweep_point(p, sweep_d[i]);
        end

        // R9: a prescale change inside a period applies from the next one.
        prescale = PW'(1);
        enable   = 1'b1;
        @(negedge clk);
        wait_fall(t0);
        prescale = PW'(5);
        @(negedge clk);
        wait_fall(t1);
        check(t1 - t0 == 40, "R9", t1 - t0, 40);
        @(negedge clk);
        wait_fall(t2);
        check(t2 - t1 == 120, "R9", t2 - t1, 120);
        go_idle();

        // R7: disabling while waiting for the line gives no further strobes.
        prescale = PW'(2);
        hold_d   = 30;
        enable   = 1'b1;
        @(negedge clk);
        while (scl_drive_low) @(negedge clk);
        enable = 1'b0;
        bad = 0;
        repeat (80) begin
            @(negedge clk);
            if (high_stb || fall_stb || scl_drive_low) bad++;
        end
        check(bad == 0, "R7", bad, 0);
        go_idle();

        // R8: a brief drop in the high phase keeps the nominal timing.
        prescale = PW'(1);
        enable   = 1'b1;
        @(negedge clk);
        wait_high(th);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        wait_fall(t1);
        check(t1 - th == 13, "R8", t1 - th, 13);
        @(negedge clk);
        // R8: a lasting drop lets the high phase end and the block go idle.
        wait_high(th);
        enable = 1'b0;
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (fall_stb || scl_drive_low) bad++;
        end
        check(bad == 0, "R8", bad, 0);
        // R2: restart from idle.
        enable = 1'b1;
        @(negedge clk);
        check(fall_stb && scl_drive_low, "R2", {fall_stb, scl_drive_low}, 3);
        go_idle();

        finish_run();
    end

    int sweep_d [6] = '{0, 1, 2, 3, 6, 20};

endmodule